// File: doc/BRIEF.md
# Ethernet Receive Frame Qualifier

This block sits between a line decoder and a receive buffer and decides, one byte at a time, what happens to each incoming frame. While hunting, it looks for a start-of-frame marker. Once it is in sync, it compares the first six bytes with the station's own address. While the address still matches, it forwards every byte to the buffer writer, and it raises `accept` when the full address has matched. If any address byte differs, it tells the writer to discard what it has stored so far.

Alongside the filtering, the block counts the frame length and runs a CRC-32 check over every byte from the destination address through the FCS. When the frame-end marker arrives, an accepted frame gets a one-cycle report. The report has three error bits (bad CRC, too short, too long) and the saturated length. Each error bit can be routed to an interrupt output through a per-class enable mask.

Top module: `rxq_frame_filter`

## Requirements
- R1: After reset, or after a frame end, the block is hunting. A byte of D5h that immediately follows a byte of 55h starts a frame. Any other byte in the hunting state, including a D5h not directly preceded by 55h, produces no write, no drop and no report.
- R2: Frame byte i (i = 0..5) is compared with `station_addr[47-8i -: 8]`. `accept` rises in the same cycle as the write strobe of byte 5 when all six bytes match. It stays high until the cycle after the frame end, when it is low again.
- R3: Each frame byte is written while all address bytes seen so far match. `wr_stb` and `wr_data` appear one clock after the byte is presented.
- R4: A frame that fails the address compare produces exactly one `drop` pulse. The pulse comes at the first differing byte, or at the frame end if the frame stops before six bytes have arrived. A failing frame produces no further writes and no report.
- R5: An accepted frame writes at most 1518 bytes. Later bytes are not written, but they are still counted and checked.
- R6: `stat_len` is the number of bytes from the destination address through the FCS, and saturates at 2047.
- R7: Status bit 1 (short frame) is set when the length is below 64.
- R8: Status bit 2 (long frame) is set when the length is above 1518.
- R9: Status bit 0 (CRC error) is set unless the CRC-32 has a residue of C704DD7Bh after all frame bytes. The CRC uses polynomial 04C11DB7h, starts at all ones, and takes bits LSB-first.
- R10: `irq` pulses together with `stat_vld` exactly when a status bit is set whose matching bit in `irq_mask` (same bit positions) is also set.
- R11: `stat_vld` is a one-cycle pulse in the cycle after `rx_frame_end`, and only for accepted frames. The frame-end cycle carries no data byte.
- R12: In reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_vld | input | 1 | A decoded byte is present this cycle |
| rx_byte | input | 8 | Decoded byte, bit 0 earliest on the wire |
| rx_frame_end | input | 1 | End of the current frame (no byte in this cycle) |
| station_addr | input | 48 | Station's individual address, first wire byte in bits 47:40 |
| irq_mask | input | 3 | Per-class interrupt enables, same bit positions as `stat` |
| accept | output | 1 | Destination address fully matched for the current frame |
| wr_stb | output | 1 | Write the byte on `wr_data` into the buffer |
| wr_data | output | 8 | Byte to write |
| drop | output | 1 | Discard what was written for the current frame |
| stat_vld | output | 1 | Report for an accepted frame is valid |
| stat | output | 3 | {long frame, short frame, CRC error} |
| stat_len | output | 11 | Frame length, saturating |
| irq | output | 1 | Interrupt pulse for enabled error classes |

## Verification
Every cycle, the assertions check these relations between outputs:
- write and drop never occur together;
- a report only follows a cycle in which `accept` was high;
- the short-frame and long-frame bits agree with the reported length;
- interrupts only occur on reports;
- the per-frame write count never passes 1518.

Only the bench scenarios can show the things that need a reference computed from the frame contents:
- the sync rules on preamble and marker byte;
- the exact byte at which a mismatching address drops the frame;
- the saturated length;
- whether the CRC check agrees with a frame built with a good or a corrupted FCS.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;
    localparam logic [7:0]  PRE_BYTE  = 8'h55;
    localparam logic [7:0]  SYNC_BYTE = 8'hD5;
    localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_GOOD  = 32'hC704_DD7B;

    typedef enum logic {PH_HUNT, PH_BODY} rxq_phase_e;

    typedef struct packed {
        logic long_frm;
        logic short_frm;
        logic crc_bad;
    } rxq_stat_t;
endpackage

// File: rtl/rxq_crc_step.sv
`timescale 1ns/1ps
module rxq_crc_step #(
    parameter int DW = 8
) (
    input  logic [31:0]   crc_in,
    input  logic [DW-1:0] data,
    output logic [31:0]   crc_out
);
    import rxq_pkg::*;

    logic [31:0] chain [0:DW];

    assign chain[0] = crc_in;

    for (genvar g = 0; g < DW; g++) begin : g_bit
        assign chain[g+1] = {chain[g][30:0], 1'b0}
                          ^ ((chain[g][31] ^ data[g]) ? CRC_POLY : 32'h0);
    end

    assign crc_out = chain[DW];
endmodule

// File: rtl/rxq_da_cmp.sv
`timescale 1ns/1ps
module rxq_da_cmp #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 11,
    localparam int ADDR_W    = 8 * ADDR_BYTES
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        data,
    output logic              eq
);
    logic [ADDR_BYTES-1:0] hit;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_pos
        assign hit[g] = (idx == IDX_W'(g))
                     && (data == addr[8*(ADDR_BYTES-1-g) +: 8]);
    end

    assign eq = |hit;
endmodule

// File: rtl/rxq_classify.sv
`timescale 1ns/1ps
module rxq_classify #(
    parameter int LEN_W   = 11,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic [LEN_W-1:0]   len,
    input  logic [31:0]        crc,
    output rxq_pkg::rxq_stat_t stat
);
    import rxq_pkg::*;

    always_comb begin
        stat           = '0;
        stat.crc_bad   = (crc != CRC_GOOD);
        stat.short_frm = (len < LEN_W'(MIN_LEN));
        stat.long_frm  = (len > LEN_W'(MAX_LEN));
    end
endmodule

// File: rtl/rxq_frame_filter.sv
`timescale 1ns/1ps
module rxq_frame_filter #(
    parameter int LEN_W      = 11,
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1518,
    parameter int ADDR_BYTES = 6,
    localparam int ADDR_W    = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    input  logic              rx_frame_end,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [2:0]        irq_mask,
    output logic              accept,
    output logic              wr_stb,
    output logic [7:0]        wr_data,
    output logic              drop,
    output logic              stat_vld,
    output logic [2:0]        stat,
    output logic [LEN_W-1:0]  stat_len,
    output logic              irq
);
    import rxq_pkg::*;

    localparam logic [LEN_W-1:0] LEN_SAT  = '1;
    localparam logic [LEN_W-1:0] DA_LAST  = LEN_W'(ADDR_BYTES - 1);
    localparam logic [LEN_W-1:0] DA_END   = LEN_W'(ADDR_BYTES);
    localparam logic [LEN_W-1:0] WR_LIMIT = LEN_W'(MAX_LEN);

    typedef struct packed {
        rxq_phase_e       phase;
        logic             pre_seen;
        logic [LEN_W-1:0] len;
        logic [31:0]      crc;
        logic             da_ok;
        logic             taken;
        logic             dropped;
        logic             wr_stb;
        logic [7:0]       wr_data;
        logic             drop;
        logic             stat_vld;
        rxq_stat_t        stat;
        logic [LEN_W-1:0] stat_len;
        logic             irq;
    } rxq_state_t;

    rxq_state_t s_q, s_d;

    logic [31:0] crc_nx;
    logic        da_eq;
    rxq_stat_t   cls;

    rxq_crc_step #(.DW(8)) u_crc (
        .crc_in (s_q.crc),
        .data   (rx_byte),
        .crc_out(crc_nx)
    );

    rxq_da_cmp #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(LEN_W)) u_cmp (
        .addr(station_addr),
        .idx (s_q.len),
        .data(rx_byte),
        .eq  (da_eq)
    );

    rxq_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_cls (
        .len (s_q.len),
        .crc (s_q.crc),
        .stat(cls)
    );

    always_comb begin
        logic match;
        s_d          = s_q;
        s_d.wr_stb   = 1'b0;
        s_d.drop     = 1'b0;
        s_d.stat_vld = 1'b0;
        s_d.irq      = 1'b0;
        match        = 1'b0;

        if (rx_frame_end) begin
            if (s_q.phase == PH_BODY) begin
                if (s_q.taken) begin
                    s_d.stat_vld = 1'b1;
                    s_d.stat     = cls;
                    s_d.stat_len = s_q.len;
                    s_d.irq      = |(cls & irq_mask);
                end else if (!s_q.dropped) begin
                    s_d.drop = 1'b1;
                end
            end
            s_d.phase    = PH_HUNT;
            s_d.pre_seen = 1'b0;
            s_d.taken    = 1'b0;
        end else if (rx_byte_vld) begin
            if (s_q.phase == PH_HUNT) begin
                if (rx_byte == PRE_BYTE) begin
                    s_d.pre_seen = 1'b1;
                end else if (rx_byte == SYNC_BYTE && s_q.pre_seen) begin
                    s_d.phase    = PH_BODY;
                    s_d.pre_seen = 1'b0;
                    s_d.len      = '0;
                    s_d.crc      = CRC_SEED;
                    s_d.da_ok    = 1'b1;
                    s_d.taken    = 1'b0;
                    s_d.dropped  = 1'b0;
                end else begin
                    s_d.pre_seen = 1'b0;
                end
            end else begin
                s_d.crc = crc_nx;
                if (s_q.len != LEN_SAT) begin
                    s_d.len = s_q.len + 1'b1;
                end
                if (s_q.len < DA_END) begin
                    match     = s_q.da_ok && da_eq;
                    s_d.da_ok = match;
                    if (s_q.da_ok && !da_eq) begin
                        s_d.drop    = 1'b1;
                        s_d.dropped = 1'b1;
                    end
                    if (match && s_q.len == DA_LAST) begin
                        s_d.taken = 1'b1;
                    end
                end else begin
                    match = s_q.taken;
                end
                if (match && s_q.len < WR_LIMIT) begin
                    s_d.wr_stb  = 1'b1;
                    s_d.wr_data = rx_byte;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.phase    <= PH_HUNT;
            s_q.crc      <= CRC_SEED;
        end else begin
            s_q <= s_d;
        end
    end

    assign accept   = s_q.taken;
    assign wr_stb   = s_q.wr_stb;
    assign wr_data  = s_q.wr_data;
    assign drop     = s_q.drop;
    assign stat_vld = s_q.stat_vld;
    assign stat     = s_q.stat;
    assign stat_len = s_q.stat_len;
    assign irq      = s_q.irq;
endmodule

// File: rtl/rxq_frame_filter_chk.sv
`timescale 1ns/1ps
module rxq_frame_filter_chk #(
    parameter int LEN_W   = 11,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input logic             clk,
    input logic             rst_n,
    input logic             accept,
    input logic             wr_stb,
    input logic             drop,
    input logic             stat_vld,
    input logic [2:0]       stat,
    input logic [LEN_W-1:0] stat_len,
    input logic             irq
);
    logic [15:0] wr_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || stat_vld || drop) begin
            wr_cnt_q <= '0;
        end else if (wr_stb) begin
            wr_cnt_q <= wr_cnt_q + 16'd1;
        end
    end

    // R3
    wr_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && drop));

    // R4
    drop_not_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> !accept);

    // R11
    report_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> ($past(accept) && !accept));

    // R11
    report_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |=> !stat_vld);

    // R7
    short_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (stat[1] == (stat_len < LEN_W'(MIN_LEN))));

    // R8
    long_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_vld |-> (stat[2] == (stat_len > LEN_W'(MAX_LEN))));

    // R10
    irq_on_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_vld && stat != 3'b000));

    // R5
    write_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_cnt_q < 16'(MAX_LEN)));
endmodule

bind rxq_frame_filter rxq_frame_filter_chk #(
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .wr_stb  (wr_stb),
    .drop    (drop),
    .stat_vld(stat_vld),
    .stat    (stat),
    .stat_len(stat_len),
    .irq     (irq)
);

// File: tb/rxq_frame_filter_bench.sv
`timescale 1ns/1ps
module rxq_frame_filter_bench;
    localparam int LEN_W   = 11;
    localparam int MIN_LEN = 64;
    localparam int MAX_LEN = 1518;
    localparam int LEN_SAT = 2047;
    localparam logic [47:0] STA = 48'h02_1A_3C_5E_70_91;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_byte_vld = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic rx_frame_end = 1'b0;
    logic [2:0] irq_mask = 3'b000;
    logic accept, wr_stb, drop, stat_vld, irq;
    logic [7:0] wr_data;
    logic [2:0] stat;
    logic [LEN_W-1:0] stat_len;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] fr [0:2199];

    always #5 clk = ~clk;

    rxq_frame_filter u_rxq_frame_filter (
        .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_frame_end(rx_frame_end), .station_addr(STA), .irq_mask(irq_mask),
        .accept(accept), .wr_stb(wr_stb), .wr_data(wr_data), .drop(drop),
        .stat_vld(stat_vld), .stat(stat), .stat_len(stat_len), .irq(irq)
    );

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        for (int i = 0; i < 8; i++)
            c = (c[31] ^ b[i]) ? ({c[30:0], 1'b0} ^ 32'h04C11DB7) : {c[30:0], 1'b0};
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        rx_byte_vld = 1'b1;
        rx_byte     = b;
        @(posedge clk);
        #1;
        rx_byte_vld = 1'b0;
    endtask

    task automatic end_frame();
        @(negedge clk);
        rx_frame_end = 1'b1;
        @(posedge clk);
        #1;
        rx_frame_end = 1'b0;
    endtask

    task automatic preamble();
        for (int i = 0; i < 7; i++) put_byte(8'h55);
        put_byte(8'hD5);
        check(!wr_stb && !accept && !drop, "R1 sync byte not written",
              {wr_stb, accept, drop}, 0);
    endtask

    // k: index of first differing address byte (6 = full match)
    task automatic run_frame(input int len, input int k, input bit bad, input logic [2:0] mask);
        logic [31:0] c;
        logic [2:0]  exp_st;
        int          exp_len;
        bit          acc;
        irq_mask = mask;
        for (int p = 0; p < len; p++) begin
            if (p < 6) fr[p] = STA[8*(5-p) +: 8] ^ ((p == k) ? 8'h01 : 8'h00);
            else       fr[p] = 8'((p * 13 + len) & 255);
        end
        if (len >= 10) begin
            c = 32'hFFFF_FFFF;
            for (int p = 0; p < len - 4; p++) c = crc_byte(c, fr[p]);
            for (int q = 0; q < 4; q++)
                for (int i = 0; i < 8; i++) fr[len-4+q][i] = ~c[31 - 8*q - i];
            if (bad) fr[len-1] = fr[len-1] ^ 8'h80;
        end
        preamble();
        for (int p = 0; p < len; p++) begin
            bit ew, ed;
            put_byte(fr[p]);
            ew = (p < 6) ? (p < k) : (k >= 6 && p < MAX_LEN);
            ed = (p == k) && (k < 6);
            if (p >= MAX_LEN)
                check(wr_stb == ew && !drop, "R5 write cap", wr_stb, ew);
            else if (ed)
                check(wr_stb == ew && drop == ed, "R4 drop at mismatch", {wr_stb, drop}, {ew, ed});
            else
                check(wr_stb == ew && drop == ed && (!ew || wr_data == fr[p]),
                      "R3 byte write", {wr_stb, drop, wr_data}, {ew, ed, fr[p]});
            if (p == 5) check(accept == (k >= 6), "R2 accept after address", accept, k >= 6);
        end
        end_frame();
        acc = (k >= 6) && (len >= 6);
        check(!accept, "R2 accept low after end", accept, 0);
        if (acc) begin
            exp_len = (len > LEN_SAT) ? LEN_SAT : len;
            exp_st  = {len > MAX_LEN, len < MIN_LEN, bad};
            check(stat_vld, "R11 report pulse", stat_vld, 1);
            check(stat_len == exp_len, "R6 length", stat_len, exp_len);
            check(stat[1] == exp_st[1], "R7 short bit", stat[1], exp_st[1]);
            check(stat[2] == exp_st[2], "R8 long bit", stat[2], exp_st[2]);
            check(stat[0] == exp_st[0], "R9 crc bit", stat[0], exp_st[0]);
            check(irq == |(exp_st & mask), "R10 irq", irq, |(exp_st & mask));
            @(posedge clk); #1;
            check(!stat_vld && !irq, "R11 single pulse", {stat_vld, irq}, 0);
        end else begin
            check(!stat_vld && !irq, "R11 no report when rejected", {stat_vld, irq}, 0);
            check(drop == (k >= len), "R4 drop at end of short frame", drop, k >= len);
        end
    endtask

    task automatic stray_bytes(input string req);
        for (int p = 0; p < 20; p++) begin
            put_byte((p < 6) ? STA[8*(5-p) +: 8] : 8'(p));
            check(!wr_stb && !drop && !accept, req, {wr_stb, drop, accept}, 0);
        end
        end_frame();
        check(!stat_vld && !drop, req, {stat_vld, drop}, 0);
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lens [8] = '{10, 63, 64, 65, 300, 1518, 1519, 2100};
        repeat (3) @(posedge clk);
        #1;
        // R12
        check({accept, wr_stb, drop, stat_vld, irq} == 0, "R12 reset outputs",
              {accept, wr_stb, drop, stat_vld, irq}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: sync byte without preamble, then with a broken preamble
        put_byte(8'hD5);
        stray_bytes("R1 no sync without preamble");
        put_byte(8'h55); put_byte(8'h00); put_byte(8'hD5);
        stray_bytes("R1 no sync after broken preamble");

        for (int i = 0; i < 8; i++)
            for (int b = 0; b < 2; b++)
                run_frame(lens[i], 6, b[0], 3'(i + b));

        for (int k = 0; k < 6; k++) run_frame(80, k, 1'b0, 3'b111);

        run_frame(4, 6, 1'b0, 3'b111);

        for (int m = 0; m < 8; m++) run_frame(63, 6, 1'b1, 3'(m));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule